// File: doc/BRIEF.md
# Configurable UART Frame Engine

This block serialises characters onto a UART transmit line and deserialises characters from a receive line, with the character format and the bit period set through a small register port. Software picks a character length of five to eight bits, optional parity with odd or even sense, and one or two stop bits. A 21-bit divisor gives the bit period directly in clock cycles, so the divisor is the reference clock rate divided by the wanted baud rate. For example, 26 MHz at 115200 baud gives 225, which is the reset value.

The transmitter takes one byte at a time from a FIFO through a valid/ready handshake. The receiver hands each finished character to a FIFO together with a status byte. The status byte carries parity, framing, break and overrun indications. When the receive FIFO reports full, the finished character is dropped, and the overrun is reported on the next character that is delivered. A control bit routes the transmit line internally into the receiver, and while it is set the external receive pin is ignored.

Top module: `uart_frame_engine`

## Requirements
- R1: Line-control register (address 0) bits [3:2] set the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Transmitted characters use the low bits of the byte, LSB first, and the rest of the byte is ignored.
- R2: Line-control bit 1 enables a parity bit after the data bits. Line-control bit 0 selects odd parity (1) or even parity (0). Even parity makes the count of ones in data plus parity even.
- R3: Line-control bit 5 selects two stop bits when set and one stop bit when clear. The value 0x10 in bits [5:4] gives one stop bit and 0x30 gives two.
- R4: The divisor is split across two registers. Address 1 holds divisor bits [15:0] and address 2 holds bits [20:16] in its bits [4:0]. Each bit lasts exactly divisor clock cycles, and divisors below 4 act as 4. Every register reads back at its own address.
- R5: The transmit line idles high. A frame is a low start bit, then the data bits, then the parity bit if enabled, then the high stop bits.
- R6: tx_ready is high only while the transmitter is idle. A byte is taken on a clock edge where tx_valid and tx_ready are both high, and the start bit appears on the next cycle.
- R7: The receiver samples each bit at mid-bit and delivers the character right-aligned in rx_data, with the unused upper bits zero. rx_valid is a one-cycle pulse.
- R8: A parity bit that does not match the selected sense sets rx_status bit 2.
- R9: Any stop bit sampled low sets rx_status bit 3.
- R10: A frame with every data bit, the parity bit and the first stop bit all low is a break. A break sets rx_status bit 7 and clears rx_status bits 3 and 2.
- R11: A character that completes while rx_full is high is not delivered. rx_status bit 4 is then set on the next delivered character, and on no character after that.
- R12: Control register (address 3) bit 14 feeds the transmit line to the receiver, and serial_rx is then ignored.
- R13: A low pulse on the receive line shorter than half a bit period does not start a character.
- R14: After reset: serial_tx is 1, tx_ready is 1, rx_valid is 0, line control is 0x1C (8 data bits, no parity, 1 stop bit), the divisor is 225 and loopback is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| tx_valid | input | 1 | Transmit byte available |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmitter idle, byte accepted |
| rx_full | input | 1 | Receive FIFO cannot accept |
| rx_valid | output | 1 | Received character strobe |
| rx_data | output | 8 | Received character, right-aligned |
| rx_status | output | 8 | Error flags: 7 break, 4 overrun, 3 framing, 2 parity |
| serial_tx | output | 1 | Serial transmit line |
| serial_rx | input | 1 | Serial receive line |

## Verification
The bench checks three short formats (5 bits with even parity and two stops, 7 bits odd, 6 bits even) alongside 8N1. A design that ignored the length or parity fields would put the wrong number of bits on the line, or would leave stray upper bits in rx_data.

It drives a break, a frame with a low stop bit and a frame with a flipped parity bit. A design that did not mask the other flags on a break would report a framing or parity error with it.

Overrun is checked across three frames. A design that delivered the dropped character, lost the pending flag, or never cleared it would be caught.

A sub-half-bit glitch and a low external pin during loopback are both applied. A design that started a character on a glitch, or listened to the pin in loopback, would deliver a spurious or corrupted character.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
  localparam int DIV_W   = 21;
  localparam int LCR_W   = 6;
  localparam int MIN_DIV = 4;

  // status bit positions
  localparam int ST_PE = 2;
  localparam int ST_FE = 3;
  localparam int ST_OE = 4;
  localparam int ST_BK = 7;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
  } frame_cfg_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD
  } ser_state_t;

  function automatic frame_cfg_t decode_lcr(input logic [LCR_W-1:0] lcr);
    frame_cfg_t c;
    c.len      = lcr[3:2];
    c.par_en   = lcr[1];
    c.par_odd  = lcr[0];
    c.two_stop = lcr[5];
    return c;
  endfunction

  function automatic logic [3:0] char_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  function automatic logic [7:0] len_mask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input logic [1:0] len,
                                   input logic odd);
    return (^(d & len_mask(len))) ^ odd;
  endfunction

  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    return (d < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : d;
  endfunction
endpackage

// File: rtl/uart_fe_regs.sv
module uart_fe_regs
  import uart_fe_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 16,
  parameter int LOOP_BIT = 14,
  parameter logic [LCR_W-1:0] RST_LCR = 6'h1C,
  parameter logic [DIV_W-1:0] RST_DIV = 21'd225
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [LCR_W-1:0]  lcr,
  output logic [DIV_W-1:0]  divisor,
  output logic              loop_en
);
  localparam logic [ADDR_W-1:0] A_LCR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DLO  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DHI  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(3);
  localparam int HI_W = DIV_W - DATA_W;

  logic [DATA_W-1:0] div_lo;
  logic [HI_W-1:0]   div_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr     <= RST_LCR;
      div_lo  <= RST_DIV[DATA_W-1:0];
      div_hi  <= RST_DIV[DIV_W-1:DATA_W];
      loop_en <= 1'b0;
    end else if (we) begin
      case (addr)
        A_LCR:   lcr     <= wdata[LCR_W-1:0];
        A_DLO:   div_lo  <= wdata;
        A_DHI:   div_hi  <= wdata[HI_W-1:0];
        default: loop_en <= wdata[LOOP_BIT];
      endcase
    end
  end

  assign divisor = {div_hi, div_lo};

  always_comb begin
    rdata = '0;
    case (addr)
      A_LCR:   rdata[LCR_W-1:0] = lcr;
      A_DLO:   rdata            = div_lo;
      A_DHI:   rdata[HI_W-1:0]  = div_hi;
      A_CTRL:  rdata[LOOP_BIT]  = loop_en;
      default: rdata            = '0;
    endcase
  end
endmodule

// File: rtl/uart_fe_tx.sv
module uart_fe_tx
  import uart_fe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic [LCR_W-1:0] lcr,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             txd
);
  ser_state_t       st;
  frame_cfg_t       cfg;
  logic [DIV_W-1:0] div_q, cnt;
  logic [7:0]       shr;
  logic [2:0]       idx;
  logic             sidx, par_q;
  logic             bit_end, last_data;

  assign bit_end   = (cnt == div_q - 1'b1);
  assign last_data = ({1'b0, idx} == char_bits(cfg.len) - 4'd1);
  assign tx_ready  = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cfg <= '0; div_q <= DIV_W'(MIN_DIV); cnt <= '0;
      shr <= '0; idx <= '0; sidx <= 1'b0; par_q <= 1'b0; txd <= 1'b1;
    end else if (st == S_IDLE) begin
      if (tx_valid) begin
        cfg   <= decode_lcr(lcr);
        div_q <= eff_div(divisor);
        shr   <= tx_data;
        par_q <= par_bit(tx_data, lcr[3:2], lcr[0]);
        cnt   <= '0;
        txd   <= 1'b0;
        st    <= S_START;
      end
    end else if (!bit_end) begin
      cnt <= cnt + 1'b1;
    end else begin
      cnt <= '0;
      case (st)
        S_START: begin
          txd <= shr[0]; shr <= shr >> 1; idx <= '0; st <= S_DATA;
        end
        S_DATA: begin
          if (last_data) begin
            sidx <= 1'b0;
            if (cfg.par_en) begin txd <= par_q; st <= S_PAR;  end
            else            begin txd <= 1'b1;  st <= S_STOP; end
          end else begin
            txd <= shr[0]; shr <= shr >> 1; idx <= idx + 1'b1;
          end
        end
        S_PAR: begin txd <= 1'b1; st <= S_STOP; end
        default: begin
          txd <= 1'b1;
          if (sidx == cfg.two_stop) st <= S_IDLE;
          else sidx <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx
  import uart_fe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic [LCR_W-1:0] lcr,
  input  logic             rxd_raw,
  input  logic             rx_full,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic [7:0]       rx_status,
  output logic             char_done,
  output logic             char_drop
);
  ser_state_t       st;
  frame_cfg_t       cfg;
  logic [DIV_W-1:0] div_q, cnt;
  logic [7:0]       shr, stat_now;
  logic [2:0]       idx;
  logic             s1, s2, sidx;
  logic             zero, pe, fe, brk, ovr;
  logic             bit_end, brk_now, fe_now, last_stop, last_data;

  assign bit_end   = (cnt == div_q - 1'b1);
  assign last_data = ({1'b0, idx} == char_bits(cfg.len) - 4'd1);
  assign last_stop = (sidx == cfg.two_stop);
  assign brk_now   = sidx ? brk : (zero & ~s2);
  assign fe_now    = fe | ~s2;
  assign char_done = (st == S_STOP) && bit_end && last_stop;
  assign char_drop = char_done && rx_full;

  always_comb begin
    stat_now        = '0;
    stat_now[ST_BK] = brk_now;
    stat_now[ST_OE] = ovr;
    stat_now[ST_FE] = fe_now & ~brk_now;
    stat_now[ST_PE] = pe & ~brk_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1;
      st <= S_IDLE; cfg <= '0; div_q <= DIV_W'(MIN_DIV); cnt <= '0;
      shr <= '0; idx <= '0; sidx <= 1'b0;
      zero <= 1'b0; pe <= 1'b0; fe <= 1'b0; brk <= 1'b0; ovr <= 1'b0;
      rx_valid <= 1'b0; rx_data <= '0; rx_status <= '0;
    end else begin
      s1 <= rxd_raw;
      s2 <= s1;
      rx_valid <= 1'b0;
      case (st)
        S_IDLE: if (!s2) begin
          cfg <= decode_lcr(lcr); div_q <= eff_div(divisor);
          cnt <= '0; st <= S_START;
        end
        S_START: begin
          if (cnt == (div_q >> 1) - 1'b1) begin
            cnt <= '0;
            if (!s2) begin
              st <= S_DATA; idx <= '0; shr <= '0; zero <= 1'b1;
              pe <= 1'b0; fe <= 1'b0; brk <= 1'b0;
            end else st <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: begin
          if (bit_end) begin
            cnt <= '0;
            shr[idx] <= s2;
            zero <= zero & ~s2;
            if (last_data) begin
              sidx <= 1'b0;
              st   <= cfg.par_en ? S_PAR : S_STOP;
            end else idx <= idx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        S_PAR: begin
          if (bit_end) begin
            cnt  <= '0;
            pe   <= (s2 != par_bit(shr, cfg.len, cfg.par_odd));
            zero <= zero & ~s2;
            st   <= S_STOP;
          end else cnt <= cnt + 1'b1;
        end
        S_STOP: begin
          if (bit_end) begin
            cnt <= '0;
            brk <= brk_now;
            fe  <= fe_now;
            if (last_stop) begin
              if (rx_full) ovr <= 1'b1;
              else begin
                rx_valid <= 1'b1; rx_data <= shr;
                rx_status <= stat_now; ovr <= 1'b0;
              end
              st <= s2 ? S_IDLE : S_HOLD;
            end else sidx <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: if (s2) st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
  import uart_fe_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tx_valid,
  input  logic [7:0]        tx_data,
  output logic              tx_ready,
  input  logic              rx_full,
  output logic              rx_valid,
  output logic [7:0]        rx_data,
  output logic [7:0]        rx_status,
  output logic              serial_tx,
  input  logic              serial_rx
);
  logic [LCR_W-1:0] lcr;
  logic [DIV_W-1:0] bit_div;
  logic             loop_en, rx_line, char_done, char_drop;

  uart_fe_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .lcr(lcr),
    .divisor(bit_div), .loop_en(loop_en)
  );

  uart_fe_tx u_tx (
    .clk(clk), .rst_n(rst_n), .divisor(bit_div), .lcr(lcr),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .txd(serial_tx)
  );

  assign rx_line = loop_en ? serial_tx : serial_rx;

  uart_fe_rx u_rx (
    .clk(clk), .rst_n(rst_n), .divisor(bit_div), .lcr(lcr),
    .rxd_raw(rx_line), .rx_full(rx_full), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_status(rx_status),
    .char_done(char_done), .char_drop(char_drop)
  );
endmodule

// File: rtl/uart_frame_engine_chk.sv
module uart_frame_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        serial_tx,
  input logic        rx_valid,
  input logic [7:0]  rx_status,
  input logic        rx_full,
  input logic        char_drop,
  input logic        reg_we,
  input logic [1:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic [20:0] bit_div
);
  p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> serial_tx);

  p_start_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (!tx_ready && !serial_tx));

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_break_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_status[7]) |-> (!rx_status[3] && !rx_status[2]));

  p_no_push_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
    char_drop |=> !rx_valid);

  p_div_low_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd1) |=> (bit_div[15:0] == $past(reg_wdata)));
endmodule

bind uart_frame_engine uart_frame_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .serial_tx(serial_tx), .rx_valid(rx_valid), .rx_status(rx_status),
  .rx_full(rx_full), .char_drop(char_drop), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .bit_div(bit_div)
);

// File: tb/uart_frame_engine_test.sv
module uart_frame_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_ready;
  logic        rx_full = 1'b0;
  logic        rx_valid;
  logic [7:0]  rx_data, rx_status;
  logic        serial_tx;
  logic        serial_rx = 1'b1;

  int checks = 0, failures = 0, bd = 16;
  int got_n = 0;
  logic [7:0] got_d, got_s;
  bit done = 0;

  always #10 clk = ~clk;

  uart_frame_engine uut (.*);

  always @(negedge clk) if (rx_valid) begin
    got_n++; got_d = rx_data; got_s = rx_status;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [15:0] exp);
    @(negedge clk); reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  function automatic logic parity(input logic [7:0] d, input int nb, input bit odd);
    logic p = odd;
    for (int i = 0; i < nb; i++) p ^= d[i];
    return p;
  endfunction

  // drive one frame onto serial_rx
  task automatic drive_frame(input logic [7:0] d, input int nb, input bit pen,
                             input bit odd, input int ns, input bit flip_par,
                             input bit stop_low);
    logic [11:0] bits = '1;
    int n = 0;
    bits[n++] = 1'b0;
    for (int i = 0; i < nb; i++) bits[n++] = d[i];
    if (pen) bits[n++] = parity(d, nb, odd) ^ flip_par;
    for (int i = 0; i < ns; i++) bits[n++] = ~stop_low;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); serial_rx = bits[i];
      repeat (bd - 1) @(negedge clk);
    end
    @(negedge clk); serial_rx = 1'b1;
    repeat (bd) @(negedge clk);
  endtask

  task automatic rx_expect(input string req, input int n0, input logic [7:0] d,
                           input logic [7:0] s);
    chk({req, " count"}, got_n, n0 + 1);
    chk({req, " data"}, got_d, d);
    chk({req, " status"}, got_s, s);
  endtask

  // send a byte and sample the line at each mid-bit
  task automatic tx_frame(input string req, input logic [7:0] d, input int nb,
                          input bit pen, input bit odd, input int ns);
    logic [11:0] exp = '1, got = '1;
    int n = 0;
    exp[n++] = 1'b0;
    for (int i = 0; i < nb; i++) exp[n++] = d[i];
    if (pen) exp[n++] = parity(d, nb, odd);
    for (int i = 0; i < ns; i++) exp[n++] = 1'b1;
    @(negedge clk); tx_data = d; tx_valid = 1;
    @(posedge clk);
    @(negedge clk); tx_valid = 0;
    repeat (bd / 2 - 1) @(negedge clk);
    got[0] = serial_tx;
    chk({req, " ready low in frame (R6)"}, tx_ready, 0);
    for (int k = 1; k < n; k++) begin
      repeat (bd) @(negedge clk);
      got[k] = serial_tx;
    end
    chk({req, " ready low in last stop"}, tx_ready, 0);
    chk({req, " line bits"}, got, exp);
    repeat (bd) @(negedge clk);
    chk({req, " ready after frame (R6)"}, tx_ready, 1);
  endtask

  task automatic t_reset;
    chk("R14 serial_tx", serial_tx, 1);
    chk("R14 tx_ready", tx_ready, 1);
    chk("R14 rx_valid", rx_valid, 0);
    rd_chk("R14 lcr", 2'd0, 16'h001C);
    rd_chk("R14 div lo", 2'd1, 16'd225);
    rd_chk("R14 div hi", 2'd2, 16'd0);
    rd_chk("R14 ctrl", 2'd3, 16'd0);
  endtask

  task automatic t_div_regs;
    wr(2'd1, 16'hABCD); wr(2'd2, 16'hFFFF);
    rd_chk("R4 div lo readback", 2'd1, 16'hABCD);
    rd_chk("R4 div hi 5 bits", 2'd2, 16'h001F);
    wr(2'd2, 16'd0); wr(2'd1, 16'd20); bd = 20;
    wr(2'd0, 16'h001C);
    rd_chk("R1 lcr readback", 2'd0, 16'h001C);
  endtask

  task automatic t_bit_period;
    int lo = 0;
    @(negedge clk); tx_data = 8'h80; tx_valid = 1;
    @(posedge clk);
    @(negedge clk); tx_valid = 0;
    while (serial_tx == 1'b0 && lo < 1000) begin
      lo++; @(negedge clk);
    end
    chk("R4 low span of start+7 zeros", lo, 8 * bd);
    repeat (3 * bd) @(negedge clk);
    wr(2'd1, 16'd16); bd = 16;
  endtask

  task automatic t_tx;
    wr(2'd0, 16'h001C); tx_frame("R5 8N1 A5", 8'hA5, 8, 0, 0, 1);
    wr(2'd0, 16'h0032); tx_frame("R1 R2 R3 5E2 FB", 8'hFB, 5, 1, 0, 2);
    wr(2'd0, 16'h001B); tx_frame("R2 7O1 41", 8'h41, 7, 1, 1, 1);
  endtask

  task automatic t_rx_good;
    int n0;
    wr(2'd0, 16'h001C); n0 = got_n;
    drive_frame(8'h3C, 8, 0, 0, 1, 0, 0);
    rx_expect("R7 8N1", n0, 8'h3C, 8'h00);
    wr(2'd0, 16'h0016); n0 = got_n;
    drive_frame(8'h2D, 6, 1, 0, 1, 0, 0);
    rx_expect("R7 R1 6E1 right aligned", n0, 8'h2D, 8'h00);
  endtask

  task automatic t_rx_errors;
    int n0;
    wr(2'd0, 16'h001A); n0 = got_n;
    drive_frame(8'h41, 7, 1, 0, 1, 1, 0);
    rx_expect("R8 parity error", n0, 8'h41, 8'h04);
    wr(2'd0, 16'h001C); n0 = got_n;
    drive_frame(8'h55, 8, 0, 0, 1, 0, 1);
    rx_expect("R9 framing error", n0, 8'h55, 8'h08);
    wr(2'd0, 16'h001A); n0 = got_n;
    @(negedge clk); serial_rx = 0;
    repeat (12 * bd) @(negedge clk);
    serial_rx = 1;
    repeat (2 * bd) @(negedge clk);
    rx_expect("R10 break masks fe pe", n0, 8'h00, 8'h80);
  endtask

  task automatic t_overrun;
    int n0;
    wr(2'd0, 16'h001C); n0 = got_n;
    rx_full = 1;
    drive_frame(8'h11, 8, 0, 0, 1, 0, 0);
    rx_full = 0;
    chk("R11 dropped char not delivered", got_n, n0);
    drive_frame(8'h22, 8, 0, 0, 1, 0, 0);
    rx_expect("R11 overrun on next", n0, 8'h22, 8'h10);
    drive_frame(8'h33, 8, 0, 0, 1, 0, 0);
    rx_expect("R11 overrun cleared", n0 + 1, 8'h33, 8'h00);
  endtask

  task automatic t_loop;
    int n0;
    wr(2'd3, 16'h4000);
    rd_chk("R12 ctrl readback", 2'd3, 16'h4000);
    @(negedge clk); serial_rx = 0;
    repeat (2 * bd) @(negedge clk);
    n0 = got_n;
    chk("R12 pin ignored", got_n, n0);
    @(negedge clk); tx_data = 8'h5A; tx_valid = 1;
    @(posedge clk);
    @(negedge clk); tx_valid = 0;
    repeat (12 * bd) @(negedge clk);
    rx_expect("R12 loopback", n0, 8'h5A, 8'h00);
    serial_rx = 1;
    repeat (2 * bd) @(negedge clk);
    wr(2'd3, 16'h0000);
  endtask

  task automatic t_glitch;
    int n0 = got_n;
    @(negedge clk); serial_rx = 0;
    repeat (bd / 4) @(negedge clk);
    serial_rx = 1;
    repeat (12 * bd) @(negedge clk);
    chk("R13 glitch rejected", got_n, n0);
    drive_frame(8'hC3, 8, 0, 0, 1, 0, 0);
    rx_expect("R13 next frame clean", n0, 8'hC3, 8'h00);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset;
    t_div_regs;
    t_bit_period;
    t_tx;
    t_rx_good;
    t_rx_errors;
    t_overrun;
    t_loop;
    t_glitch;
    finish_run;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run;
  end
endmodule